// File: doc/BRIEF.md
# Cascaded TDM Frame Master Generator

This block is the timing source for a time-division serial bus that links a chain of codec devices. It divides a master clock down to a serial bit clock, counts bit clocks into frames, and raises a one-bit-wide frame-sync pulse at the start of each frame. Every frame is cut into 16-bit time slots. The block reports which device of the chain owns the current slot. In continuous data mode each device owns one 16-bit slot per frame. In programming mode each device owns a 32-bit slot.

In normal operation the frame holds exactly the slots of the chain, and the bit clock is the master clock divided by P×M. In turbo operation the bit clock is the master clock divided by P. The frame then stretches to M×N×16 bit clocks, and the bits after the last device's slot are idle. Configuration inputs are sampled only at a frame boundary. A configuration error flag reports, for each frame, whether the settings it runs with are illegal.

Top module: `tdm_frame_master`

## Requirements
- R1: While `rst_n` is sampled low, `bclk`, `fsync`, `slot_valid`, `slot_owner` and `cfg_err` are all 0 after the next rising edge of `clk`.
- R2: A bit period lasts P×M `clk` cycles in normal operation and P cycles in turbo operation, with any value below 2 raised to 2. `bclk` is high for the first floor(period/2) cycles of each bit and low for the rest.
- R3: Each bit starts with a rising edge of `bclk`. `fsync` is high for exactly the first bit of every frame. The first frame starts on the first `clk` edge after reset is released.
- R4: In normal operation a frame lasts `dev_count`×16×k bits, where k is 1 when `prog_mode`=0 (continuous data) and 2 when `prog_mode`=1 (programming).
- R5: In turbo operation (`turbo_en`=1) a frame lasts M×N×16 bits.
- R6: A slot lasts 16×k bits. The slot at position j of the frame (j=0 first) belongs to device `dev_count`-1-j. `slot_owner` therefore starts each frame at `dev_count`-1, the master, and steps down by one per slot to 0.
- R7: After the last device's slot, for the rest of the frame, `slot_valid` is 0 and `slot_owner` is 0. In turbo operation this idle span lasts M×N×16 − `dev_count`×16×k bits.
- R8: `cfg_err` is 1 for a frame whose settings have P<2, M=0, N=0 or `dev_count`=0, or have turbo operation with M×N ≤ `dev_count`×k. Otherwise it is 0. It updates at the start of each frame. A frame always lasts at least 16 bits.
- R9: A change of M, N, P, `dev_count`, `turbo_en` or `prog_mode` during a frame does not alter the bit period or the length of that frame. It takes effect from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_m | input | DIV_W | Divider M |
| div_n | input | DIV_W | Divider N |
| div_p | input | DIV_W | Divider P |
| dev_count | input | DEV_W | Number of devices in the chain, master included |
| turbo_en | input | 1 | 1 selects turbo operation |
| prog_mode | input | 1 | 0 continuous data, 1 programming (32-bit slots) |
| bclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync, high for the first bit of a frame |
| slot_owner | output | DEV_W | Device owning the current slot (master = dev_count-1) |
| slot_valid | output | 1 | Current bit belongs to a device slot |
| cfg_err | output | 1 | Settings of the running frame are illegal |

## Verification
Suppose the tick counter is corrupted or the latched period is wrong. The next bit period then differs in length, which the bench measures between consecutive `bclk` rises within one bit time. A slot-tracking fault shows as a wrong `slot_owner` or `slot_valid` at the next 16- or 32-bit slot boundary. A frame-length fault shows as a misplaced `fsync` one frame later. Configuration latched at the wrong moment shows within the frame where the inputs change, as a changed bit period or a changed frame length.

// File: rtl/tdm_pkg.sv
// Shared constants and types for the cascaded TDM frame master.
// Assumes: a slot is 2**SLOT_BITS_LOG2 bits in continuous data mode.
package tdm_pkg;

    localparam int SLOT_BITS_LOG2 = 4;   // 16-bit base slot
    localparam int MIN_BIT_PERIOD = 2;   // shortest legal bit period in clk cycles

    typedef enum logic {
        XFER_CONT = 1'b0,
        XFER_PROG = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/tdm_cfg_latch.sv
// Captures the divider, device-count and mode inputs at each frame start and
// derives the bit period, high time, frame length and error flag used for
// the whole frame.
// Assumes: load pulses for one cycle on the edge that begins a frame.
module tdm_cfg_latch #(
    parameter int DIV_W = 8,
    parameter int DEV_W = 4,
    parameter int PER_W = 16,
    parameter int FRM_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_m,
    input  logic [DIV_W-1:0] div_n,
    input  logic [DIV_W-1:0] div_p,
    input  logic [DEV_W-1:0] dev_count,
    input  logic             turbo_en,
    input  logic             prog_mode,
    output logic [PER_W-1:0] period_q,
    output logic [PER_W-1:0] half_q,
    output logic [FRM_W-1:0] frame_len_q,
    output tdm_pkg::xfer_mode_e mode_q,
    output logic             err_q
);
    import tdm_pkg::*;

    localparam int UNIT_W = DEV_W + 1;
    localparam int SHIFT  = SLOT_BITS_LOG2;

    logic [PER_W-1:0]  mn_w;
    logic [UNIT_W-1:0] units_w;
    logic [PER_W-1:0]  per_raw;
    logic [PER_W-1:0]  per_w;
    logic [FRM_W-1:0]  frm_raw;
    logic [FRM_W-1:0]  frm_w;
    logic              err_w;

    // Derive the next frame's timing from the raw inputs.
    always_comb begin
        mn_w    = PER_W'(div_m) * PER_W'(div_n);
        units_w = prog_mode ? {dev_count, 1'b0} : {1'b0, dev_count};
        per_raw = turbo_en ? PER_W'(div_p) : PER_W'(div_p) * PER_W'(div_m);
        per_w   = (per_raw < PER_W'(MIN_BIT_PERIOD)) ? PER_W'(MIN_BIT_PERIOD) : per_raw;
        frm_raw = turbo_en ? (FRM_W'(mn_w) << SHIFT) : (FRM_W'(units_w) << SHIFT);
        frm_w   = (frm_raw < (FRM_W'(1) << SHIFT)) ? (FRM_W'(1) << SHIFT) : frm_raw;
        err_w   = (div_p < DIV_W'(MIN_BIT_PERIOD)) || (div_m == '0) || (div_n == '0)
                || (dev_count == '0) || (turbo_en && (mn_w <= PER_W'(units_w)));
    end

    // Hold the active settings; replace them only at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q    <= PER_W'(MIN_BIT_PERIOD);
            half_q      <= PER_W'(MIN_BIT_PERIOD / 2);
            frame_len_q <= FRM_W'(1) << SHIFT;
            mode_q      <= XFER_CONT;
            err_q       <= 1'b0;
        end else if (load) begin
            period_q    <= per_w;
            half_q      <= per_w >> 1;
            frame_len_q <= frm_w;
            mode_q      <= prog_mode ? XFER_PROG : XFER_CONT;
            err_q       <= err_w;
        end
    end

    // R9: settings stay fixed between frame starts.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(period_q) && $stable(frame_len_q) && $stable(err_q)))
        else $error("cfg changed without frame start");

endmodule

// File: rtl/tdm_bit_divider.sv
// Divides clk into the serial bit clock. A bit begins with bclk high for
// half_q cycles and ends after period_q cycles, when bit_end pulses.
// Assumes: period_q >= 2, half_q >= 1, both constant inside a bit; prime is
// high only in the first cycle after reset and forces an immediate bit end.
module tdm_bit_divider #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prime,
    input  logic [PER_W-1:0] period_q,
    input  logic [PER_W-1:0] half_q,
    output logic             bit_end,
    output logic             bclk
);
    logic [PER_W-1:0] tick_q;
    logic [PER_W-1:0] tick_inc;

    // Last cycle of the current bit (or the priming cycle after reset).
    always_comb begin
        tick_inc = tick_q + PER_W'(1);
        bit_end  = prime || (tick_inc == period_q);
    end

    // Count cycles within a bit and shape the clock as a registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            bclk   <= 1'b0;
        end else if (bit_end) begin
            tick_q <= '0;
            bclk   <= 1'b1;
        end else begin
            tick_q <= tick_inc;
            bclk   <= (tick_inc < half_q);
        end
    end

    // R2: the tick never passes the active period.
    p_tick_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n || prime)
        tick_q < period_q)
        else $error("bit tick out of range");

endmodule

// File: rtl/tdm_frame_tracker.sv
// Counts bits into frames, drives frame sync for the first bit, and tracks
// the owner of each slot from the master down to device 0.
// Assumes: bit_end marks the last cycle of a bit; mode_q and frame_len_q
// change only on the edge where frame_end is high.
module tdm_frame_tracker #(
    parameter int DEV_W = 4,
    parameter int FRM_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prime,
    input  logic             bit_end,
    input  logic [FRM_W-1:0] frame_len_q,
    input  tdm_pkg::xfer_mode_e mode_q,
    input  logic [DEV_W-1:0] dev_count,
    output logic             frame_end,
    output logic             fsync,
    output logic [DEV_W-1:0] slot_owner,
    output logic             slot_valid
);
    import tdm_pkg::*;

    localparam int SLOT_W = SLOT_BITS_LOG2 + 1;

    logic [FRM_W-1:0]  bit_q;
    logic [SLOT_W-1:0] inslot_q;
    logic [SLOT_W-1:0] slot_last;

    // Frame ends with its last bit; slot length depends on the mode.
    always_comb begin
        frame_end = bit_end && (prime || (bit_q == frame_len_q - FRM_W'(1)));
        slot_last = (mode_q == XFER_PROG) ? SLOT_W'((1 << (SLOT_BITS_LOG2 + 1)) - 1)
                                          : SLOT_W'((1 << SLOT_BITS_LOG2) - 1);
    end

    // Advance bit, slot and owner state at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q      <= '0;
            inslot_q   <= '0;
            fsync      <= 1'b0;
            slot_owner <= '0;
            slot_valid <= 1'b0;
        end else if (frame_end) begin
            bit_q      <= '0;
            inslot_q   <= '0;
            fsync      <= 1'b1;
            slot_valid <= (dev_count != '0);
            slot_owner <= (dev_count != '0) ? dev_count - DEV_W'(1) : '0;
        end else if (bit_end) begin
            bit_q <= bit_q + FRM_W'(1);
            fsync <= 1'b0;
            if (inslot_q == slot_last) begin
                inslot_q <= '0;
                if (slot_valid && (slot_owner != '0)) begin
                    slot_owner <= slot_owner - DEV_W'(1);
                end else begin
                    slot_valid <= 1'b0;
                    slot_owner <= '0;
                end
            end else begin
                inslot_q <= inslot_q + SLOT_W'(1);
            end
        end
    end

    // R4: bit position stays inside the active frame.
    p_bit_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q < frame_len_q)
        else $error("bit index beyond frame");

    // R6: within a frame the owner only steps down by one.
    p_owner_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && $past(slot_valid) && !fsync && (slot_owner != $past(slot_owner)))
        |-> (slot_owner == DEV_W'($past(slot_owner) - DEV_W'(1))))
        else $error("slot owner skipped");

endmodule

// File: rtl/tdm_frame_master.sv
// Top of the cascaded TDM frame master: divides clk into the bit clock,
// frames bits with a one-bit sync pulse and reports slot ownership for a
// chain of dev_count devices. Settings are taken at frame starts.
// Assumes: all inputs synchronous to clk.
module tdm_frame_master #(
    parameter int DIV_W = 8,
    parameter int DEV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_m,
    input  logic [DIV_W-1:0] div_n,
    input  logic [DIV_W-1:0] div_p,
    input  logic [DEV_W-1:0] dev_count,
    input  logic             turbo_en,
    input  logic             prog_mode,
    output logic             bclk,
    output logic             fsync,
    output logic [DEV_W-1:0] slot_owner,
    output logic             slot_valid,
    output logic             cfg_err
);
    import tdm_pkg::*;

    localparam int PER_W = 2 * DIV_W;
    localparam int FRM_W = PER_W + SLOT_BITS_LOG2 + 1;

    logic             prime_q;
    logic             bit_end;
    logic             frame_end;
    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] half_q;
    logic [FRM_W-1:0] frame_len_q;
    xfer_mode_e       mode_q;

    // Arm an immediate frame start on the first edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prime_q <= 1'b1;
        else        prime_q <= 1'b0;
    end

    tdm_cfg_latch #(
        .DIV_W(DIV_W), .DEV_W(DEV_W), .PER_W(PER_W), .FRM_W(FRM_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .load(frame_end),
        .div_m(div_m), .div_n(div_n), .div_p(div_p), .dev_count(dev_count),
        .turbo_en(turbo_en), .prog_mode(prog_mode),
        .period_q(period_q), .half_q(half_q), .frame_len_q(frame_len_q),
        .mode_q(mode_q), .err_q(cfg_err)
    );

    tdm_bit_divider #(
        .PER_W(PER_W)
    ) div_i (
        .clk(clk), .rst_n(rst_n), .prime(prime_q),
        .period_q(period_q), .half_q(half_q),
        .bit_end(bit_end), .bclk(bclk)
    );

    tdm_frame_tracker #(
        .DEV_W(DEV_W), .FRM_W(FRM_W)
    ) trk_i (
        .clk(clk), .rst_n(rst_n), .prime(prime_q), .bit_end(bit_end),
        .frame_len_q(frame_len_q), .mode_q(mode_q), .dev_count(dev_count),
        .frame_end(frame_end), .fsync(fsync),
        .slot_owner(slot_owner), .slot_valid(slot_valid)
    );

    // R3: a frame sync always begins together with a bit.
    p_fsync_bclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> $rose(bclk))
        else $error("fsync rose without bit start");

endmodule

// File: tb/tdm_frame_master_tb_top.sv
module tdm_frame_master_tb_top;

    localparam int CYCLE_LIMIT = 150000;

    typedef struct packed {
        logic [7:0] m;
        logic [7:0] n;
        logic [7:0] p;
        logic [3:0] dev;
        logic       turbo;
        logic       prog;
        int         per;
        int         frm;
        logic       err;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd2, 8'd2, 8'd2, 4'd2, 1'b0, 1'b0,  4,  32, 1'b0},
        '{8'd3, 8'd1, 8'd2, 4'd3, 1'b0, 1'b1,  6,  96, 1'b0},
        '{8'd4, 8'd3, 8'd2, 4'd3, 1'b1, 1'b0,  2, 192, 1'b0},
        '{8'd2, 8'd3, 8'd3, 4'd2, 1'b1, 1'b1,  3,  96, 1'b0},
        '{8'd2, 8'd2, 8'd2, 4'd4, 1'b1, 1'b0,  2,  64, 1'b1},
        '{8'd1, 8'd1, 8'd1, 4'd1, 1'b0, 1'b0,  2,  16, 1'b1},
        '{8'd5, 8'd2, 8'd2, 4'd1, 1'b0, 1'b0, 10,  16, 1'b0},
        '{8'd5, 8'd1, 8'd4, 4'd2, 1'b1, 1'b1,  4,  80, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] div_m, div_n, div_p;
    logic [3:0] dev_count;
    logic       turbo_en, prog_mode;
    logic       bclk, fsync, slot_valid, cfg_err;
    logic [3:0] slot_owner;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic last_b = 1'b0, last_f = 1'b0, rise_b, rise_f;

    always #5 clk = ~clk;

    tdm_frame_master dut_i (
        .clk(clk), .rst_n(rst_n), .div_m(div_m), .div_n(div_n), .div_p(div_p),
        .dev_count(dev_count), .turbo_en(turbo_en), .prog_mode(prog_mode),
        .bclk(bclk), .fsync(fsync), .slot_owner(slot_owner),
        .slot_valid(slot_valid), .cfg_err(cfg_err)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic step();
        @(negedge clk);
        rise_b = bclk && !last_b;
        rise_f = fsync && !last_f;
        last_b = bclk;
        last_f = fsync;
        cyc++;
        if (cyc > CYCLE_LIMIT) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, CYCLE_LIMIT);
            summary();
            $finish;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        div_m = v.m; div_n = v.n; div_p = v.p;
        dev_count = v.dev; turbo_en = v.turbo; prog_mode = v.prog;
    endtask

    task automatic run_vec(input vec_t v);
        int cnt, hi, fsw, b, bad, idle, slot, pos, eo, per, used, exp_idle;
        logic ev;
        apply(v);
        do step(); while (!rise_f);
        chk("R8 cfg_err", int'(cfg_err), int'(v.err));
        chk("R3 bclk rises with fsync", int'(rise_b), 1);
        slot = v.prog ? 32 : 16;
        b = 0; cnt = 0; per = -1; bad = 0; idle = 0;
        hi = int'(bclk); fsw = int'(fsync);
        forever begin
            pos = b / slot;
            ev  = (pos < int'(v.dev));
            eo  = ev ? int'(v.dev) - 1 - pos : 0;
            if (rise_b || b == 0) begin
                if (slot_valid != ev || int'(slot_owner) != eo) bad++;
                if (!slot_valid) idle++;
            end
            step();
            cnt++;
            if (rise_b) begin
                if (per < 0) per = cnt;
                if (rise_f) break;
                b++;
            end
            if (b == 0 && bclk) hi++;
            if (fsync) fsw++;
        end
        chk("R2 bit period", per, v.per);
        chk("R2 high time", hi, v.per / 2);
        chk("R3 fsync width", fsw, v.per);
        if (v.turbo) chk("R5 frame bits", b + 1, v.frm);
        else         chk("R4 frame bits", b + 1, v.frm);
        chk("R6 R7 owner mismatches", bad, 0);
        used = int'(v.dev) * slot;
        exp_idle = (v.frm > used) ? v.frm - used : 0;
        chk("R7 idle bits", idle, exp_idle);
    endtask

    initial begin
        int cnt, bits;
        rst_n = 1'b0;
        apply(VECS[0]);
        repeat (3) step();
        chk("R1 bclk in reset", int'(bclk), 0);
        chk("R1 fsync in reset", int'(fsync), 0);
        chk("R1 slot_valid in reset", int'(slot_valid), 0);
        chk("R1 owner in reset", int'(slot_owner), 0);
        chk("R1 cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        step();
        chk("R3 first fsync after reset", int'(fsync), 1);
        chk("R3 first bclk after reset", int'(bclk), 1);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R9: mid-frame change of P must wait for the next frame.
        apply(VECS[0]);
        do step(); while (!rise_f);
        do step(); while (!rise_f);
        bits = 1;
        while (bits < 3) begin step(); if (rise_b) bits++; end
        div_p = 8'd3;
        do step(); while (!rise_b);
        bits++;
        cnt = 0;
        do begin step(); cnt++; end while (!rise_b);
        bits++;
        chk("R9 period kept mid-frame", cnt, 4);
        forever begin
            step();
            if (rise_b) begin
                if (rise_f) break;
                bits++;
            end
        end
        chk("R9 frame length kept", bits, 32);
        cnt = 0;
        do begin step(); cnt++; end while (!rise_b);
        chk("R9 new period at next frame", cnt, 6);

        // R1: reset during a running erroneous configuration.
        run_vec(VECS[4]);
        rst_n = 1'b0;
        step();
        chk("R1 bclk after mid-run reset", int'(bclk), 0);
        chk("R1 fsync after mid-run reset", int'(fsync), 0);
        chk("R1 slot_valid after mid-run reset", int'(slot_valid), 0);
        chk("R1 cfg_err after mid-run reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        step();
        chk("R3 restart after reset", int'(fsync), 1);

        summary();
        $finish;
    end

endmodule